// File: doc/BRIEF.md
# Dual-Lane Q15 Rounding Saturating Multiplier

This block multiplies two packed vectors of signed Q15 fractions. Each 32-bit operand carries two independent 16-bit lanes, the upper lane in bits 31:16 and the lower lane in bits 15:0. Each pair of matching lanes is multiplied as two's-complement fractions. The product is doubled to Q31 and then rounded to nearest by adding half of a result LSB before the upper half is kept. The result lanes are packed back into the same bit positions.

The only product that cannot be represented is -1.0 times -1.0. In that case the lane result is clamped to the largest positive Q15 value. An overflow flag is then raised at bit 21 of a 32-bit control/status register. Software writes that register and reads it back through a simple write port and a read-data output. The multiplier only ever sets the flag. It stays set until software writes the register again.

A one-cycle strobe starts an operation. The packed result and the flag update appear together on the next cycle.

Top module: `q15_dual_mul`

## Requirements
- R1: The two lanes are computed independently, and each lane's result sits in the same bit positions as its inputs: bits 31:16 for the upper lane and bits 15:0 for the lower lane.
- R2: For lane inputs a and b that are not both 0x8000, the lane result is bits 31:16 of (2·a·b + 0x8000), with a and b read as signed 16-bit values. For example, 0x80011234 times 0x80024321 gives 0x7FFD098C.
- R3: When both inputs of a lane are 0x8000, that lane's result is 0x7FFF and bit 21 of the control register reads 1 after the operation. This holds whether one lane or both lanes saturate.
- R4: An operation in which no lane saturates leaves bit 21 of a cleared control register at 0.
- R5: Once set, bit 21 stays at 1 across later operations until the control register is written.
- R6: After reset the control register reads 0. A write loads all 32 bits, and they read back one cycle later.
- R7: When a register write and a saturating operation occur in the same cycle, bit 21 reads 1 and the other 31 bits take the written value.
- R8: After reset, result and res_valid are 0. res_valid is high for exactly the one cycle after each start, and result changes only on the cycle after a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on opa and opb |
| opa | input | 32 | First packed Q15 operand |
| opb | input | 32 | Second packed Q15 operand |
| res_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Packed rounded Q15 products |
| ctl_we | input | 1 | Write enable for the control register |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register contents |

## Verification
A start or a register write is sampled on one rising edge. The packed result, res_valid, the overflow bit and any written register value are all due on the very next cycle. Every bench task drives its inputs on a falling edge and holds them through one rising edge. It then samples the outputs on the following falling edge, so each check lands in the cycle where the value is due. To confirm the one-cycle window, checks also sample res_valid and the held result a cycle later.

// File: rtl/q15_mul_pkg.sv
package q15_mul_pkg;
  localparam int unsigned Q_W    = 16;
  localparam int unsigned LANE_N = 2;
  localparam int unsigned CTL_W  = 32;
  localparam int unsigned OVF_BIT = 21;
endpackage

// File: rtl/q15_lane.sv
module q15_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         sat
);
  localparam logic [W-1:0]   MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]   MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [2*W-1:0] HALF_LSB = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] round_mul(input logic [W-1:0] x, input logic [W-1:0] z);
    logic signed [2*W-1:0] prod;
    logic [2*W-1:0] dbl;
    logic [2*W-1:0] rnd;
    prod = $signed(x) * $signed(z);
    dbl  = {prod[2*W-2:0], 1'b0};
    rnd  = dbl + HALF_LSB;
    return rnd[2*W-1:W];
  endfunction

  assign sat = (a == MOST_NEG) && (b == MOST_NEG);
  assign y   = sat ? MOST_POS : round_mul(a, b);
endmodule

// File: rtl/q15_ctl_reg.sv
module q15_ctl_reg #(
  parameter int unsigned CW  = 32,
  parameter int unsigned BIT = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          set_ovf,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (we) q <= wdata;
      if (set_ovf) q[BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/q15_dual_mul.sv
module q15_dual_mul
  import q15_mul_pkg::*;
#(
  parameter int unsigned W     = Q_W,
  parameter int unsigned LANES = LANE_N,
  parameter int unsigned CW    = CTL_W,
  parameter int unsigned FBIT  = OVF_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W*LANES-1:0] opa,
  input  logic [W*LANES-1:0] opb,
  output logic               res_valid,
  output logic [W*LANES-1:0] result,
  input  logic               ctl_we,
  input  logic [CW-1:0]      ctl_wdata,
  output logic [CW-1:0]      ctl_rdata
);
  localparam int unsigned DW = W * LANES;

  logic [DW-1:0]    lane_y;
  logic [LANES-1:0] lane_sat;
  logic             sat_any;
  logic             ovf_set;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    q15_lane #(.W(W)) u_lane (
      .a  (opa[i*W +: W]),
      .b  (opb[i*W +: W]),
      .y  (lane_y[i*W +: W]),
      .sat(lane_sat[i])
    );
  end

  assign sat_any = |lane_sat;
  assign ovf_set = start && sat_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) result <= lane_y;
    end
  end

  q15_ctl_reg #(.CW(CW), .BIT(FBIT)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ctl_we),
    .wdata  (ctl_wdata),
    .set_ovf(ovf_set),
    .q      (ctl_rdata)
  );
endmodule

// File: rtl/q15_dual_mul_chk.sv
module q15_dual_mul_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 32,
  parameter int unsigned FBIT = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sat_any,
  input logic          res_valid,
  input logic [DW-1:0] result,
  input logic          ctl_we,
  input logic [CW-1:0] ctl_wdata,
  input logic [CW-1:0] ctl_rdata
);
  p_valid_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);
  p_valid_only_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  p_sat_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sat_any) |=> ctl_rdata[FBIT]);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !(start && sat_any) && !ctl_rdata[FBIT]) |=> !ctl_rdata[FBIT]);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[FBIT] && !ctl_we) |=> ctl_rdata[FBIT]);
  p_write_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !(start && sat_any)) |=> (ctl_rdata == $past(ctl_wdata)));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && start && sat_any) |=>
      (ctl_rdata == ($past(ctl_wdata) | (CW'(1) << FBIT))));
endmodule

bind q15_dual_mul q15_dual_mul_chk #(.DW(W*LANES), .CW(CW), .FBIT(FBIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .sat_any  (sat_any),
  .res_valid(res_valid),
  .result   (result),
  .ctl_we   (ctl_we),
  .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata)
);

// File: tb/q15_dual_mul_test.sv
`timescale 1ns/1ps
module q15_dual_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        res_valid;
  logic [31:0] result;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  q15_dual_mul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .res_valid(res_valid), .result(result),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
    longint sa, sb, v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (sa == -32768 && sb == -32768) return 16'h7FFF;
    v = (sa * sb * 2 + 32768) >>> 16;
    return v[15:0];
  endfunction

  function automatic logic [31:0] ref_pack(input logic [31:0] a, input logic [31:0] b);
    return {ref_lane(a[31:16], b[31:16]), ref_lane(a[15:0], b[15:0])};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset result", result, 32'h0);
    check("R8 reset valid", {31'b0, res_valid}, 32'h0);
    check("R6 reset ctl", ctl_rdata, 32'h0);
  endtask

  task automatic t_known;
    write_ctl(32'h0);
    run_op(32'h80011234, 32'h80024321);
    check("R2 known vector", result, 32'h7FFD098C);
    check("R1 known vector ref", result, ref_pack(32'h80011234, 32'h80024321));
    check("R8 valid after start", {31'b0, res_valid}, 32'h1);
    check("R4 flag clear", {31'b0, ctl_rdata[21]}, 32'h0);
  endtask

  task automatic t_signs;
    logic [31:0] va [6];
    logic [31:0] vb [6];
    logic [31:0] ve [6];
    va[0] = 32'hC0008000; vb[0] = 32'h40007FFF; ve[0] = 32'hE0008001;
    va[1] = 32'h00010001; vb[1] = 32'h40003FFF; ve[1] = 32'h00010000;
    va[2] = 32'hFFFFFFFF; vb[2] = 32'h40004001; ve[2] = 32'h0000FFFF;
    va[3] = 32'h7FFF8001; vb[3] = 32'h7FFF7FFF; ve[3] = ref_pack(32'h7FFF8001, 32'h7FFF7FFF);
    va[4] = 32'h12348765; vb[4] = 32'hFEDC0123; ve[4] = ref_pack(32'h12348765, 32'hFEDC0123);
    va[5] = 32'h00000000; vb[5] = 32'h8000ABCD; ve[5] = 32'h00000000;
    write_ctl(32'h0);
    for (int i = 0; i < 6; i++) begin
      run_op(va[i], vb[i]);
      check("R2 signed rounding", result, ve[i]);
    end
    check("R4 flag still clear", {31'b0, ctl_rdata[21]}, 32'h0);
  endtask

  task automatic t_one_lane_sat;
    write_ctl(32'h0);
    run_op(32'h80000001, 32'h80004000);
    check("R3 upper lane sat", result, 32'h7FFF0001);
    check("R3 flag upper", {31'b0, ctl_rdata[21]}, 32'h1);
    write_ctl(32'h0);
    run_op(32'hC0008000, 32'h40008000);
    check("R1 lower lane sat", result, 32'hE0007FFF);
    check("R3 flag lower", {31'b0, ctl_rdata[21]}, 32'h1);
  endtask

  task automatic t_both_sat;
    write_ctl(32'h0);
    run_op(32'h80008000, 32'h80008000);
    check("R3 both sat", result, 32'h7FFF7FFF);
    check("R3 both flag", ctl_rdata, 32'h00200000);
  endtask

  task automatic t_sticky;
    run_op(32'h11112222, 32'h33334444);
    check("R5 sticky after plain op", {31'b0, ctl_rdata[21]}, 32'h1);
    write_ctl(32'h0);
    check("R5 cleared by write", ctl_rdata, 32'h0);
  endtask

  task automatic t_ctl_rw;
    write_ctl(32'hA5A55A5A);
    check("R6 readback a", ctl_rdata, 32'hA5A55A5A);
    write_ctl(32'h12345678);
    check("R6 readback b", ctl_rdata, 32'h12345678);
  endtask

  task automatic t_priority;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 32'h000000FF;
    start = 1'b1; opa = 32'h80008000; opb = 32'h80000000;
    @(negedge clk);
    ctl_we = 1'b0; start = 1'b0;
    check("R7 set wins", ctl_rdata, 32'h002000FF);
    check("R7 result", result, 32'h7FFF0000);
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    run_op(32'h40004000, 32'h40002000);
    kept = result;
    check("R2 hold vector", kept, 32'h20001000);
    opa = 32'h7FFF7FFF; opb = 32'h7FFF7FFF;
    @(negedge clk);
    check("R8 valid one cycle", {31'b0, res_valid}, 32'h0);
    @(negedge clk);
    check("R8 result held", result, kept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_known();
    t_signs();
    t_one_lane_sat();
    t_both_sat();
    t_sticky();
    t_ctl_rw();
    t_priority();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule